// File: doc/BRIEF.md
# Standby Mode Controller

This block decides when the processor core of a small microcontroller may sleep and when it must wake. Software writes a two-bit mode code into a write-only byte register on the peripheral bus. Code 01 enters the light sleep state (HALT), in which only the core clock is stopped. Code 10 enters the deep sleep state (STOP), in which the core and peripheral clocks are both stopped. The block drives the two clock-stop requests to the clock gating cells, which sit outside it.

Deep sleep is guarded by an arming register. Software must write 0x05 and then 0x0A to it, with no other bus write in between, before a STOP request is accepted. The arming is used up by one STOP entry. No sleep request is accepted while any interrupt is both enabled and requesting. Wake-up is computed combinationally from the request and enable vectors, so it works with every gated clock stopped. The wake is reported as a one-cycle pulse. It comes with a flag that says whether the core should take the interrupt or only resume at the next instruction.

Top module: `standby_ctrl`

## Requirements
- R1: After reset, cpu_clk_stop, periph_clk_stop, wake and service_irq are all 0, and the block is in run mode.
- R2: A write of code 01 in bits 1:0 to the mode register at MODE_ADDR in run mode enters HALT: cpu_clk_stop=1 and periph_clk_stop=0 from the cycle after the write. Bits 7:2 of the written byte are ignored. Mode writes made while not in run mode are ignored.
- R3: A write of code 10 enters STOP (cpu_clk_stop=1, periph_clk_stop=1) only when the arming register is armed. Otherwise the block stays in run mode.
- R4: The arming register at UNLOCK_ADDR is armed by a write of 0x05 followed directly by a write of 0x0A. Any bus write between them, or any other value written to it, leaves it unarmed. One STOP entry disarms it.
- R5: A write of code 11 is ignored and the block stays in run mode.
- R6: A HALT or STOP request is ignored while irq_en & irq_req has any bit set.
- R7: HALT is left when wdt_irq=1 or when any bit of irq_en & irq_req is set. A request whose enable bit is 0 does not wake HALT.
- R8: STOP is left only by an enabled request at interrupt index 0, 1, 2, 3, 4 or 8. Requests at other indices, and wdt_irq, do not wake STOP.
- R9: On a wake, the mode returns to run and wake=1 for exactly one cycle. In that same cycle, cpu_clk_stop and periph_clk_stop are already 0.
- R10: service_irq is 1 during the wake pulse if master_ie was 1 when the wake was taken, and 0 otherwise. It is 0 outside wake pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock of the block |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Bus write strobe, one cycle per access |
| bus_addr | input | ADDR_W | Bus write address |
| bus_wdata | input | 8 | Bus write data |
| irq_en | input | N_IRQ | Interrupt enable flags |
| irq_req | input | N_IRQ | Interrupt request flags |
| wdt_irq | input | 1 | Watchdog interrupt request |
| master_ie | input | 1 | Core master interrupt enable |
| cpu_clk_stop | output | 1 | Request to stop the core clock |
| periph_clk_stop | output | 1 | Request to stop the peripheral clocks |
| wake | output | 1 | One-cycle pulse when a sleep mode ends |
| service_irq | output | 1 | The wake should vector to the interrupt handler |

## Verification
A wrong mode register shows at once on the clock-stop outputs, one cycle after the write or the wake that caused it. So each entry, each refusal and each release is visible at the ports in the cycle after its stimulus. A stale or missed arming state does not show until the next STOP attempt, which then wrongly enters or wrongly stays in run mode. The bench therefore follows every arming sequence with a STOP request. A wrong wake source mask shows only while in STOP, so each interrupt index is tried on its own from deep sleep.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'b00,
    MODE_HALT = 2'b01,
    MODE_STOP = 2'b10
  } sbc_mode_e;

  typedef enum logic [1:0] {
    ARM_IDLE = 2'b00,
    ARM_HALF = 2'b01,
    ARM_SET  = 2'b10
  } sbc_arm_e;

  localparam logic [1:0] CODE_RUN  = 2'b00;
  localparam logic [1:0] CODE_HALT = 2'b01;
  localparam logic [1:0] CODE_STOP = 2'b10;
  localparam logic [1:0] CODE_BAD  = 2'b11;

  localparam logic [7:0] ARM_KEY_FIRST  = 8'h05;
  localparam logic [7:0] ARM_KEY_SECOND = 8'h0A;

endpackage

// File: rtl/sbc_unlock.sv
module sbc_unlock
  import sbc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic       any_wr,
  input  logic [7:0] key_data,
  input  logic       stop_entry,
  output logic       armed
);

  sbc_arm_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (stop_entry) begin
      state_d = ARM_IDLE;
    end else if (key_wr) begin
      if (key_data == ARM_KEY_FIRST)
        state_d = ARM_HALF;
      else if (key_data == ARM_KEY_SECOND && state_q == ARM_HALF)
        state_d = ARM_SET;
      else
        state_d = ARM_IDLE;
    end else if (any_wr && state_q == ARM_HALF) begin
      state_d = ARM_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ARM_IDLE;
    else        state_q <= state_d;
  end

  assign armed = (state_q == ARM_SET);

  // R4: one STOP entry uses up the arming
  assert_arm_consumed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_entry |=> !armed);

  // R4: arming needs the second key right after the first
  assert_arm_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed ##1 armed) |-> ($past(key_wr) && $past(key_data) == ARM_KEY_SECOND));

endmodule

// File: rtl/sbc_wake_eval.sv
module sbc_wake_eval #(
  parameter int              N_IRQ     = 16,
  parameter logic [N_IRQ-1:0] STOP_MASK = 16'h011F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic             wdt_irq,
  output logic             pending,
  output logic             halt_wake,
  output logic             stop_wake
);

  function automatic logic masked_any(input logic [N_IRQ-1:0] en,
                                      input logic [N_IRQ-1:0] req,
                                      input logic [N_IRQ-1:0] mask);
    return |(en & req & mask);
  endfunction

  logic [N_IRQ-1:0] all_ones;
  assign all_ones  = '1;

  assign pending   = masked_any(irq_en, irq_req, all_ones);
  assign halt_wake = wdt_irq | pending;
  assign stop_wake = masked_any(irq_en, irq_req, STOP_MASK);

  // R8: every deep-sleep wake source also releases light sleep
  assert_stop_src_subset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_wake |-> halt_wake);

endmodule

// File: rtl/sbc_mode_fsm.sv
module sbc_mode_fsm
  import sbc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_wr,
  input  logic [1:0] mode_code,
  input  logic       pending,
  input  logic       armed,
  input  logic       halt_wake,
  input  logic       stop_wake,
  input  logic       master_ie,
  output sbc_mode_e  mode,
  output logic       stop_entry,
  output logic       wake_pulse,
  output logic       service
);

  sbc_mode_e mode_q, mode_d;
  logic      entry_ok, halt_entry, wake_now;
  logic      wake_q, svc_q;

  assign entry_ok   = mode_wr && (mode_q == MODE_RUN) && !pending;
  assign halt_entry = entry_ok && (mode_code == CODE_HALT);
  assign stop_entry = entry_ok && (mode_code == CODE_STOP) && armed;
  assign wake_now   = ((mode_q == MODE_HALT) && halt_wake) ||
                      ((mode_q == MODE_STOP) && stop_wake);

  always_comb begin
    mode_d = mode_q;
    if (wake_now)        mode_d = MODE_RUN;
    else if (halt_entry) mode_d = MODE_HALT;
    else if (stop_entry) mode_d = MODE_STOP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RUN;
      wake_q <= 1'b0;
      svc_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      wake_q <= wake_now;
      svc_q  <= wake_now & master_ie;
    end
  end

  assign mode       = mode_q;
  assign wake_pulse = wake_q;
  assign service    = svc_q;

  // R6: no sleep entry while an enabled request is pending
  assert_refuse_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_RUN && mode_wr && pending) |=> mode_q == MODE_RUN);

  // R5: the prohibited code leaves run mode untouched
  assert_bad_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_RUN && mode_wr && mode_code == CODE_BAD) |=> mode_q == MODE_RUN);

  // R3: STOP is reached only with the arming present
  assert_stop_needs_arm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MODE_STOP ##1 mode_q == MODE_STOP) |-> $past(armed));

  // R9: the mode is already run when the pulse shows
  assert_wake_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |-> mode_q == MODE_RUN);

endmodule

// File: rtl/standby_ctrl.sv
module standby_ctrl
  import sbc_pkg::*;
#(
  parameter int               ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] MODE_ADDR   = 16'hF009,
  parameter logic [ADDR_W-1:0] UNLOCK_ADDR = 16'hF008,
  parameter int               N_IRQ       = 16,
  parameter logic [N_IRQ-1:0]  STOP_MASK   = 16'h011F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic [N_IRQ-1:0]  irq_en,
  input  logic [N_IRQ-1:0]  irq_req,
  input  logic              wdt_irq,
  input  logic              master_ie,
  output logic              cpu_clk_stop,
  output logic              periph_clk_stop,
  output logic              wake,
  output logic              service_irq
);

  logic      mode_wr, key_wr, armed, stop_entry;
  logic      pending, halt_wake, stop_wake;
  sbc_mode_e mode;

  assign mode_wr = bus_wr && (bus_addr == MODE_ADDR);
  assign key_wr  = bus_wr && (bus_addr == UNLOCK_ADDR);

  sbc_unlock u_unlock (
    .clk        (clk),
    .rst_n      (rst_n),
    .key_wr     (key_wr),
    .any_wr     (bus_wr),
    .key_data   (bus_wdata),
    .stop_entry (stop_entry),
    .armed      (armed)
  );

  sbc_wake_eval #(
    .N_IRQ     (N_IRQ),
    .STOP_MASK (STOP_MASK)
  ) u_wake (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_en    (irq_en),
    .irq_req   (irq_req),
    .wdt_irq   (wdt_irq),
    .pending   (pending),
    .halt_wake (halt_wake),
    .stop_wake (stop_wake)
  );

  sbc_mode_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_wr    (mode_wr),
    .mode_code  (bus_wdata[1:0]),
    .pending    (pending),
    .armed      (armed),
    .halt_wake  (halt_wake),
    .stop_wake  (stop_wake),
    .master_ie  (master_ie),
    .mode       (mode),
    .stop_entry (stop_entry),
    .wake_pulse (wake),
    .service    (service_irq)
  );

  assign cpu_clk_stop    = (mode != MODE_RUN);
  assign periph_clk_stop = (mode == MODE_STOP);

  // R2: peripheral clocks never stop while the core clock runs
  assert_clk_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    periph_clk_stop |-> cpu_clk_stop);

  // R9: wake lasts a single cycle
  assert_wake_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);

  // R10: service request only travels with a wake
  assert_service_with_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
    service_irq |-> wake);

endmodule

// File: tb/standby_ctrl_tb.sv
module standby_ctrl_tb_top;

  localparam int          CLK_PERIOD = 10;
  localparam int          N_IRQ      = 16;
  localparam logic [15:0] A_MODE     = 16'hF009;
  localparam logic [15:0] A_KEY      = 16'hF008;
  localparam logic [15:0] A_OTHER    = 16'hF010;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             bus_wr = 1'b0;
  logic [15:0]      bus_addr = '0;
  logic [7:0]       bus_wdata = '0;
  logic [N_IRQ-1:0] irq_en = '0;
  logic [N_IRQ-1:0] irq_req = '0;
  logic             wdt_irq = 1'b0;
  logic             master_ie = 1'b0;
  logic             cpu_clk_stop, periph_clk_stop, wake, service_irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  standby_ctrl dut_i (
    .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_addr (bus_addr),
    .bus_wdata (bus_wdata), .irq_en (irq_en), .irq_req (irq_req),
    .wdt_irq (wdt_irq), .master_ie (master_ie), .cpu_clk_stop (cpu_clk_stop),
    .periph_clk_stop (periph_clk_stop), .wake (wake), .service_irq (service_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // state as {cpu_clk_stop, periph_clk_stop}
  function automatic logic [31:0] clk_state();
    return {30'd0, cpu_clk_stop, periph_clk_stop};
  endfunction

  function automatic logic stop_source(input int idx);
    return (idx <= 4) || (idx == 8);
  endfunction

  task automatic bus_write(input logic [15:0] addr, input logic [7:0] data);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = addr; bus_wdata = data;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic arm();
    bus_write(A_KEY, 8'h05);
    bus_write(A_KEY, 8'h0A);
  endtask

  task automatic clear_irqs();
    irq_en = '0; irq_req = '0; wdt_irq = 1'b0;
    @(negedge clk);
  endtask

  // raise a request from a negedge, look one edge later
  task automatic wake_by(input int idx, input logic use_wdt, input logic [31:0] exp_wake,
                         input string req);
    if (use_wdt) wdt_irq = 1'b1;
    else begin irq_en[idx] = 1'b1; irq_req[idx] = 1'b1; end
    @(negedge clk);
    chk(req, {31'd0, wake}, exp_wake);
  endtask

  task automatic t_reset();
    chk("R1 clocks", clk_state(), 0);
    chk("R1 wake", {31'd0, wake}, 0);
    chk("R1 service", {31'd0, service_irq}, 0);
  endtask

  task automatic t_halt();
    master_ie = 1'b1;
    bus_write(A_MODE, 8'hFD);           // upper bits set, code 01
    chk("R2 halt entry", clk_state(), 2);
    bus_write(A_MODE, 8'h00);           // ignored outside run
    chk("R2 write in halt ignored", clk_state(), 2);
    irq_en = 16'h0004; irq_req = 16'h0008;   // enable and request apart
    @(negedge clk);
    chk("R7 disabled request no wake", clk_state(), 2);
    irq_en = '0; irq_req = '0;
    wake_by(3, 1'b0, 1, "R7 enabled request wake");
    chk("R9 clocks back on with pulse", clk_state(), 0);
    chk("R10 service with mie", {31'd0, service_irq}, 1);
    clear_irqs();
    chk("R9 pulse one cycle", {31'd0, wake}, 0);
    chk("R10 service drops", {31'd0, service_irq}, 0);
    bus_write(A_MODE, 8'h01);
    wake_by(0, 1'b1, 1, "R7 watchdog wake");
    clear_irqs();
  endtask

  task automatic t_stop_unarmed();
    bus_write(A_MODE, 8'h02);
    chk("R3 unarmed stop refused", clk_state(), 0);
    bus_write(A_KEY, 8'h05);
    bus_write(A_OTHER, 8'h00);
    bus_write(A_KEY, 8'h0A);
    bus_write(A_MODE, 8'h02);
    chk("R4 interrupted sequence", clk_state(), 0);
    bus_write(A_KEY, 8'h0A);
    bus_write(A_KEY, 8'h05);
    bus_write(A_MODE, 8'h02);
    chk("R4 reversed order", clk_state(), 0);
  endtask

  task automatic t_stop_sources();
    master_ie = 1'b0;
    for (int i = 0; i < N_IRQ; i++) begin
      arm();
      bus_write(A_MODE, 8'h02);
      chk("R3 stop entry", clk_state(), 3);
      wake_by(i, 1'b0, {31'd0, stop_source(i)}, "R8 stop source");
      if (!stop_source(i)) begin
        chk("R8 still stopped", clk_state(), 3);
        irq_en[0] = 1'b1; irq_req[0] = 1'b1;
        @(negedge clk);
      end else begin
        chk("R10 no service with mie 0", {31'd0, service_irq}, 0);
      end
      clear_irqs();
    end
    arm();
    bus_write(A_MODE, 8'h02);
    wake_by(0, 1'b1, 0, "R8 watchdog ignored in stop");
    wake_by(8, 1'b0, 1, "R8 source 8");
    clear_irqs();
  endtask

  task automatic t_arm_consumed();
    arm();
    bus_write(A_MODE, 8'h02);
    wake_by(1, 1'b0, 1, "R4 first stop wake");
    clear_irqs();
    bus_write(A_MODE, 8'h02);
    chk("R4 arming consumed", clk_state(), 0);
  endtask

  task automatic t_bad_code();
    arm();
    bus_write(A_MODE, 8'h03);
    chk("R5 code 11 ignored", clk_state(), 0);
    bus_write(A_MODE, 8'h02);
    chk("R5 arming kept after bad code", clk_state(), 3);
    wake_by(2, 1'b0, 1, "R5 recovery wake");
    clear_irqs();
  endtask

  task automatic t_pending();
    irq_en = 16'h0040; irq_req = 16'h0040;
    bus_write(A_MODE, 8'h01);
    chk("R6 halt refused", clk_state(), 0);
    arm();
    bus_write(A_MODE, 8'h02);
    chk("R6 stop refused", clk_state(), 0);
    chk("R6 no wake", {31'd0, wake}, 0);
    clear_irqs();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_halt();
    t_stop_unarmed();
    t_stop_sources();
    t_arm_consumed();
    t_bad_code();
    t_pending();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule